// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master from a free-running base oscillator. The low phase and the high phase of SCL each last a programmed number of oscillator periods, set independently through two 8-bit count inputs. A 2-bit speed-class input picks one of four bus classes. Each class imposes its own floor on the low and the high counts, so a count that is too small for the selected class cannot shorten the waveform.

The generator drives SCL only as an open-drain enable: while `scl_oe` is high the pad pulls the line low, and otherwise the line is released. The high phase counts only those oscillator periods in which the line is sensed high. A slave that holds SCL low therefore stretches the clock, and the generator resumes counting once the line rises. Two single-cycle strobes help the byte engine above: one in the middle of each low phase to launch the next SDA value, and one in the middle of each high phase to sample SDA. Clearing the enable releases the line and returns both counters to zero.

Top module: `scl_timing_gen`

## Requirements
- R1: While `en` is low, `scl_oe`, `launch_stb` and `sample_stb` are all low from the next clock edge on. A later enable starts a fresh low phase of full length.
- R2: Out of reset all outputs are low. On the first clock edge with `en` high, `scl_oe` rises.
- R3: With no stretching, `scl_oe` stays low for exactly the effective high count of clock cycles before it rises again.
- R4: The effective count is the larger of the programmed count and the speed-class floor. The `mode` encoding and its floors (low/high) are: 0 = standard 157/134, 1 = fast 44/20, 2 = fast-plus 17/9, 3 = turbo 14/5.
- R5: A programmed count at or above the floor is used unchanged, up to 255. `scl_oe` stays high for exactly the effective low count of cycles.
- R6: Each clock edge of the high phase at which `scl_in` is sensed low holds the high counter. Each such edge lengthens the released time by one cycle.
- R7: `launch_stb` is high for exactly one cycle per low phase, in the low-phase cycle whose zero-based index is floor(effective low / 2). It is never high while `scl_oe` is low.
- R8: `sample_stb` is high for exactly one cycle per high phase, when the high counter first reaches floor(effective high / 2). That is released cycle index stretch + floor(effective high / 2). It is never high while `scl_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the clock when high; releases SCL when low |
| mode | input | 2 | Speed class: 0 standard, 1 fast, 2 fast-plus, 3 turbo |
| low_cnt | input | 8 | Requested low-phase length in oscillator periods |
| high_cnt | input | 8 | Requested high-phase length in oscillator periods |
| scl_in | input | 1 | Sensed SCL line level (synchronous to clk) |
| scl_oe | output | 1 | High to pull SCL low |
| launch_stb | output | 1 | One-cycle strobe in the middle of the low phase |
| sample_stb | output | 1 | One-cycle strobe in the middle of the high phase |

## Verification
The bench builds the block with its default 8-bit count width. At that width a single period lasts at most about 510 cycles. This makes it affordable to sweep all four speed classes against requested counts of zero, one below the floor, the floor, one above it and 255, on both phases. These sweeps reach both sides of every clamp boundary and the odd/even midpoint cases of both strobes. Further runs stretch the high phase by several cycles, and one run disables the generator in the middle of a low phase and then re-enables it.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    SPD_STANDARD = 2'd0,
    SPD_FAST     = 2'd1,
    SPD_FASTPLUS = 2'd2,
    SPD_TURBO    = 2'd3
  } spd_class_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Shortest allowed low phase per speed class, in oscillator periods.
  function automatic int unsigned low_floor(input logic [1:0] cls);
    case (cls)
      SPD_STANDARD: return 157;
      SPD_FAST:     return 44;
      SPD_FASTPLUS: return 17;
      default:      return 14;
    endcase
  endfunction

  // Shortest allowed high phase per speed class, in oscillator periods.
  function automatic int unsigned high_floor(input logic [1:0] cls);
    case (cls)
      SPD_STANDARD: return 134;
      SPD_FAST:     return 20;
      SPD_FASTPLUS: return 9;
      default:      return 5;
    endcase
  endfunction

endpackage

// File: rtl/scl_count_clamp.sv
module scl_count_clamp
  import scl_timing_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter bit HIGH_SIDE = 1'b0
) (
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] req_cnt,
  output logic [CNT_W-1:0] eff_cnt
);

  logic [CNT_W-1:0] floor_cnt;

  generate
    if (HIGH_SIDE) begin : g_high
      always_comb floor_cnt = CNT_W'(high_floor(mode));
    end else begin : g_low
      always_comb floor_cnt = CNT_W'(low_floor(mode));
    end
  endgenerate

  always_comb eff_cnt = (req_cnt < floor_cnt) ? floor_cnt : req_cnt;

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] eff_low,
  input  logic [CNT_W-1:0] eff_high,
  output logic             scl_oe,
  output logic             launch_stb,
  output logic             sample_stb,
  output scl_phase_e       phase,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] half_low, half_high, cnt_inc;
  logic [CNT_W-1:0] last_low, last_high;
  scl_phase_e       nxt_phase;
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_launch, nxt_sample;

  always_comb begin
    half_low  = eff_low >> 1;
    half_high = eff_high >> 1;
    last_low  = eff_low - 1'b1;
    last_high = eff_high - 1'b1;
    cnt_inc   = cnt + 1'b1;
  end

  always_comb begin
    nxt_phase  = phase;
    nxt_cnt    = cnt;
    nxt_launch = 1'b0;
    nxt_sample = 1'b0;
    if (!en) begin
      nxt_phase = PH_OFF;
      nxt_cnt   = '0;
    end else begin
      case (phase)
        PH_OFF: begin
          nxt_phase = PH_LOW;
          nxt_cnt   = '0;
        end
        PH_LOW: begin
          if (cnt >= last_low) begin
            nxt_phase = PH_HIGH;
            nxt_cnt   = '0;
          end else begin
            nxt_cnt    = cnt_inc;
            nxt_launch = (cnt_inc == half_low);
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (cnt >= last_high) begin
              nxt_phase = PH_LOW;
              nxt_cnt   = '0;
            end else begin
              nxt_cnt    = cnt_inc;
              nxt_sample = (cnt_inc == half_high);
            end
          end
        end
        default: begin
          nxt_phase = PH_OFF;
          nxt_cnt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_OFF;
      cnt        <= '0;
      scl_oe     <= 1'b0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      phase      <= nxt_phase;
      cnt        <= nxt_cnt;
      scl_oe     <= (nxt_phase == PH_LOW);
      launch_stb <= nxt_launch;
      sample_stb <= nxt_sample;
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             launch_stb,
  output logic             sample_stb
);

  logic [CNT_W-1:0] eff_low, eff_high;
  scl_phase_e       seq_phase;
  logic [CNT_W-1:0] seq_cnt;

  scl_count_clamp #(.CNT_W(CNT_W), .HIGH_SIDE(1'b0)) u_low_clamp (
    .mode    (mode),
    .req_cnt (low_cnt),
    .eff_cnt (eff_low)
  );

  scl_count_clamp #(.CNT_W(CNT_W), .HIGH_SIDE(1'b1)) u_high_clamp (
    .mode    (mode),
    .req_cnt (high_cnt),
    .eff_cnt (eff_high)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .scl_in     (scl_in),
    .eff_low    (eff_low),
    .eff_high   (eff_high),
    .scl_oe     (scl_oe),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .phase      (seq_phase),
    .cnt        (seq_cnt)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       mode,
  input logic             scl_in,
  input logic             scl_oe,
  input logic             launch_stb,
  input logic             sample_stb,
  input scl_phase_e       seq_phase,
  input logic [CNT_W-1:0] seq_cnt
);

  logic [CNT_W:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || !en)     low_run <= '0;
    else if (scl_oe)    low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_oe && !launch_stb && !sample_stb));

  assert_low_not_below_floor_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_oe) && $past(en) && en) |-> (int'(low_run) >= int'(low_floor(mode))));

  assert_stretch_holds_count_R6: assert property (@(posedge clk) disable iff (rst)
    (en && seq_phase == PH_HIGH && !scl_in) |=> (seq_phase == PH_HIGH && $stable(seq_cnt)));

  assert_launch_in_low_R7: assert property (@(posedge clk) disable iff (rst)
    launch_stb |-> scl_oe);

  assert_launch_single_R7: assert property (@(posedge clk) disable iff (rst)
    launch_stb |=> !launch_stb);

  assert_sample_released_R8: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> !scl_oe);

  assert_sample_single_R8: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

endmodule

bind scl_timing_gen scl_timing_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .mode       (mode),
  .scl_in     (scl_in),
  .scl_oe     (scl_oe),
  .launch_stb (launch_stb),
  .sample_stb (sample_stb),
  .seq_phase  (seq_phase),
  .seq_cnt    (seq_cnt)
);

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] low_cnt = 8'd0;
  logic [7:0] high_cnt = 8'd0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_oe, launch_stb, sample_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  // Open-drain line: low when the master pulls or a slave holds it.
  assign scl_in = !scl_oe && !hold;

  scl_timing_gen u0 (
    .clk(clk), .rst(rst), .en(en), .mode(mode),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_in(scl_in),
    .scl_oe(scl_oe), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int floor_lo(input int m);
    case (m)
      0: return 157;
      1: return 44;
      2: return 17;
      default: return 14;
    endcase
  endfunction

  function automatic int floor_hi(input int m);
    case (m)
      0: return 134;
      1: return 20;
      2: return 9;
      default: return 5;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Measures one low phase followed by one released phase, starting at the
  // first negedge where scl_oe is high.
  task automatic measure(input int exp_lo, input int exp_hi, input int stretch, input string tag);
    int n = 0, m = 0, guard = 0;
    int l_at = -1, l_num = 0, s_at = -1, s_num = 0;
    while (!scl_oe && guard < 2000) begin @(negedge clk); guard++; end
    while (scl_oe && n < 2000) begin
      if (launch_stb) begin l_num++; l_at = n; end
      if (sample_stb) s_num++;
      n++;
      @(negedge clk);
    end
    while (!scl_oe && m < 2000) begin
      hold = (m < stretch);
      if (sample_stb) begin s_num++; s_at = m; end
      if (launch_stb) l_num++;
      m++;
      @(negedge clk);
    end
    hold = 1'b0;
    chk(n == exp_lo, {tag, " R5 low length"}, n, exp_lo);
    chk(m == exp_hi + stretch, {tag, " R3/R6 released length"}, m, exp_hi + stretch);
    chk(l_num == 1 && l_at == exp_lo / 2, {tag, " R7 launch position"}, l_at, exp_lo / 2);
    chk(s_num == 1 && s_at == stretch + exp_hi / 2, {tag, " R8 sample position"}, s_at,
        stretch + exp_hi / 2);
  endtask

  task automatic run_case(input int md, input int lo, input int hi, input int stretch);
    int elo, ehi;
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!scl_oe && !launch_stb && !sample_stb, "R1 idle while disabled",
        {scl_oe, launch_stb, sample_stb}, 0);
    mode = md[1:0]; low_cnt = lo[7:0]; high_cnt = hi[7:0];
    elo = imax(lo, floor_lo(md));
    ehi = imax(hi, floor_hi(md));
    en = 1'b1;
    @(negedge clk);
    chk(scl_oe, "R2 low phase begins one edge after enable", scl_oe, 1);
    measure(elo, ehi, stretch, $sformatf("R4 mode=%0d lo=%0d hi=%0d", md, lo, hi));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !launch_stb && !sample_stb, "R2 reset state",
        {scl_oe, launch_stb, sample_stb}, 0);
    rst = 1'b0;

    // Boundary sweep of both counts around each speed-class floor.
    for (int md = 0; md < 4; md++) begin
      for (int a = 0; a < 5; a++) begin
        for (int b = 0; b < 5; b++) begin
          int lo, hi;
          lo = (a == 0) ? 0 : (a == 4) ? 255 : floor_lo(md) + a - 2;
          hi = (b == 0) ? 0 : (b == 4) ? 255 : floor_hi(md) + b - 2;
          run_case(md, lo, hi, 0);
        end
      end
    end

    // Clock stretching in the high phase (R6).
    run_case(3, 14, 5, 1);
    run_case(3, 20, 9, 7);
    run_case(1, 50, 30, 12);
    run_case(2, 0, 0, 3);

    // Disable in the middle of a low phase, then restart (R1).
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    mode = 2'd0; low_cnt = 8'd160; high_cnt = 8'd140;
    en = 1'b1;
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_oe, "R1 released after mid-phase disable", scl_oe, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!scl_oe && !launch_stb && !sample_stb, "R1 stays released",
          {scl_oe, launch_stb, sample_stb}, 0);
    end
    en = 1'b1;
    measure(160, 140, 0, "R1 restart full length");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule